// File: doc/BRIEF.md
# Home-Bus Handoff Controller

This controller sits beside the arbiter of one memory column in a processor-to-memory crossbar. It decides when the column's own (home) processor is attached to the column bus and when that processor is held stalled. After reset it attaches the processor, waits for the processor clock phase, and then lets it run for as long as the home processor keeps both the grant and its own request.

There are two ways the home processor gives the bus up. In the first, a remote processor wins the column: the controller stalls the home processor and then detaches it, and it stays detached until the grant comes back. In the second, the home processor addresses a remote column, which drops its home request. The controller then makes sure the arbiter has released the home grant, pulsing an acknowledge if it has not. It detaches the processor and waits for the grant to return. When the grant comes back it reattaches the processor. It then pulses a clear, together with the acknowledge, which resets the processor's remote-request flag.

Each path has its own detach and reattach states. The controller runs on a controller clock eight times faster than the processor clock. It samples the processor clock phase through an optional synchronizer whose depth is a parameter.

Top module: `home_bus_handoff`

## Requirements
- R1: While rst_ni is low the outputs are pause=1, connect=0, ack=0, clear=0, taking effect without waiting for a clock edge. The first clock edge after release gives pause=1, connect=1 (the attach-stalled state).
- R2: In the attach-stalled state the outputs hold while the sampled phase is 0. On an edge with phase 1 the controller enters the run state, where pause=0 and connect=1.
- R3: In the run state the controller stays put when grant and request are both 1 or both 0.
- R4: In the run state, grant=0 with request=1 gives one cycle of pause=1, connect=1. It is followed by the detached-stalled state, pause=1 and connect=0, which holds while grant is 0. A grant of 1 there returns to the attach-stalled state.
- R5: In the run state, grant=1 with request=0 moves to a check state whose outputs are the run state's outputs. If grant is still 1 there, ack=1 is driven for exactly one cycle, and then the controller detaches (all outputs 0).
- R6: In the check state with grant already 0, the controller detaches directly, with no ack.
- R7: The detached state (all outputs 0) holds while grant is 0. Grant=1 reattaches with pause=0, connect=1, and the controller holds there while phase is 0.
- R8: Phase=1 in the reattach state produces one cycle with connect=1, ack=1 and clear=1. The controller then returns to the run state. Clear is never asserted without ack.
- R9: Pause and ack are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock (8x processor clock) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Arbiter grant of this column to the home processor |
| home_req_i | input | 1 | Home processor is addressing its own column |
| cpu_phase_i | input | 1 | Processor clock level, sampled by clk_i |
| pause_o | output | 1 | Stall the home processor |
| connect_o | output | 1 | Attach the home processor to the column bus |
| ack_o | output | 1 | Acknowledge to the arbiter |
| clear_o | output | 1 | Reset the processor's remote-request flag |

## Verification
The bench builds the controller with PHASE_SYNC=0, so a phase change reaches the state machine on the very next edge. With that setting, every transition in the ten-state sequence lands exactly one clock after its stimulus. A single table can then walk both give-up paths, each of their hold loops, and both exits from the check state, comparing all four outputs at every step. An asynchronous reset in the middle of the run confirms that the stall state is restored without a clock.

// File: rtl/hbh_pkg.sv
package hbh_pkg;
  typedef enum logic [3:0] {
    ST_RESET = 4'd0,
    ST_CON1  = 4'd1,
    ST_RUN   = 4'd2,
    ST_CHECK = 4'd3,
    ST_ACK   = 4'd4,
    ST_DISC  = 4'd5,
    ST_CON2  = 4'd6,
    ST_CLEAR = 4'd7,
    ST_PAUSE = 4'd8,
    ST_PDISC = 4'd9
  } hbh_state_e;

  typedef struct packed {
    logic pause;
    logic connect;
    logic ack;
    logic clear;
  } hbh_out_t;
endpackage

// File: rtl/hbh_phase_sync.sv
module hbh_phase_sync #(
  parameter int unsigned STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-1:0] << 1} | {{(STAGES-1){1'b0}}, d_i};
      end
      assign q_o = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hbh_next_state.sv
module hbh_next_state
  import hbh_pkg::*;
(
  input  hbh_state_e state_i,
  input  logic       grant_i,
  input  logic       req_i,
  input  logic       phase_i,
  output hbh_state_e next_o
);
  always_comb begin
    next_o = state_i;
    unique case (state_i)
      ST_RESET: next_o = ST_CON1;
      ST_CON1:  if (phase_i) next_o = ST_RUN;
      ST_RUN: begin
        if (grant_i && !req_i)      next_o = ST_CHECK;
        else if (!grant_i && req_i) next_o = ST_PAUSE;
      end
      ST_CHECK: next_o = grant_i ? ST_ACK : ST_DISC;
      ST_ACK:   next_o = ST_DISC;
      ST_DISC:  if (grant_i) next_o = ST_CON2;
      ST_CON2:  if (phase_i) next_o = ST_CLEAR;
      ST_CLEAR: next_o = ST_RUN;
      ST_PAUSE: next_o = ST_PDISC;
      ST_PDISC: if (grant_i) next_o = ST_CON1;
      default:  next_o = ST_RESET;
    endcase
  end
endmodule

// File: rtl/hbh_out_decode.sv
module hbh_out_decode
  import hbh_pkg::*;
(
  input  hbh_state_e state_i,
  output hbh_out_t   out_o
);
  always_comb begin
    out_o = '{pause: 1'b1, connect: 1'b0, ack: 1'b0, clear: 1'b0};
    unique case (state_i)
      ST_RESET: out_o = '{pause: 1'b1, connect: 1'b0, ack: 1'b0, clear: 1'b0};
      ST_CON1:  out_o = '{pause: 1'b1, connect: 1'b1, ack: 1'b0, clear: 1'b0};
      ST_RUN:   out_o = '{pause: 1'b0, connect: 1'b1, ack: 1'b0, clear: 1'b0};
      ST_CHECK: out_o = '{pause: 1'b0, connect: 1'b1, ack: 1'b0, clear: 1'b0};
      ST_ACK:   out_o = '{pause: 1'b0, connect: 1'b1, ack: 1'b1, clear: 1'b0};
      ST_DISC:  out_o = '{pause: 1'b0, connect: 1'b0, ack: 1'b0, clear: 1'b0};
      ST_CON2:  out_o = '{pause: 1'b0, connect: 1'b1, ack: 1'b0, clear: 1'b0};
      ST_CLEAR: out_o = '{pause: 1'b0, connect: 1'b1, ack: 1'b1, clear: 1'b1};
      ST_PAUSE: out_o = '{pause: 1'b1, connect: 1'b1, ack: 1'b0, clear: 1'b0};
      ST_PDISC: out_o = '{pause: 1'b1, connect: 1'b0, ack: 1'b0, clear: 1'b0};
      default:  out_o = '{pause: 1'b1, connect: 1'b0, ack: 1'b0, clear: 1'b0};
    endcase
  end
endmodule

// File: rtl/home_bus_handoff.sv
module home_bus_handoff
  import hbh_pkg::*;
#(
  parameter int unsigned PHASE_SYNC = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic home_req_i,
  input  logic cpu_phase_i,
  output logic pause_o,
  output logic connect_o,
  output logic ack_o,
  output logic clear_o
);
  hbh_state_e state_q, state_d;
  hbh_out_t   outs;
  logic       phase_s;

  hbh_phase_sync #(.STAGES(PHASE_SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cpu_phase_i),
    .q_o    (phase_s)
  );

  hbh_next_state u_next (
    .state_i (state_q),
    .grant_i (grant_i),
    .req_i   (home_req_i),
    .phase_i (phase_s),
    .next_o  (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  hbh_out_decode u_dec (
    .state_i (state_q),
    .out_o   (outs)
  );

  assign pause_o   = outs.pause;
  assign connect_o = outs.connect;
  assign ack_o     = outs.ack;
  assign clear_o   = outs.clear;

  // R1: leaving reset always lands in attach-stalled
  p_reset_exit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESET) |=> (pause_o && connect_o));

  // R4: detached-stalled holds while grant is low
  p_pdisc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PDISC && !grant_i) |=> (pause_o && !connect_o));

  // R5: plain ack lasts one cycle and is followed by detach
  p_ack_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !clear_o) |=> (!ack_o && !connect_o));

  // R7: detached state holds while grant is low
  p_disc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DISC && !grant_i) |=> (!connect_o && !pause_o));

  // R8
  p_clear_needs_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> ack_o);
  p_clear_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> (!clear_o && !ack_o && connect_o && !pause_o));

  // R9
  p_pause_ack_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pause_o && ack_o));
endmodule

// File: tb/home_bus_handoff_tb.sv
module home_bus_handoff_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic grant_i = 1'b0;
  logic home_req_i = 1'b0;
  logic cpu_phase_i = 1'b0;
  logic pause_o, connect_o, ack_o, clear_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  home_bus_handoff #(.PHASE_SYNC(0)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant_i),
    .home_req_i  (home_req_i),
    .cpu_phase_i (cpu_phase_i),
    .pause_o     (pause_o),
    .connect_o   (connect_o),
    .ack_o       (ack_o),
    .clear_o     (clear_o)
  );

  // {req tag, grant, req, phase, pause, connect, ack, clear}
  localparam int NV = 23;
  localparam logic [10:0] VEC [NV] = '{
    {4'd1, 3'b110, 4'b1100},  // R1 first edge -> attach-stalled
    {4'd2, 3'b110, 4'b1100},  // R2 hold on phase low
    {4'd2, 3'b111, 4'b0100},  // R2 run
    {4'd3, 3'b110, 4'b0100},  // R3 both high
    {4'd3, 3'b000, 4'b0100},  // R3 both low
    {4'd5, 3'b100, 4'b0100},  // R5 check state
    {4'd5, 3'b100, 4'b0110},  // R5 ack pulse
    {4'd5, 3'b100, 4'b0000},  // R5 detach
    {4'd7, 3'b000, 4'b0000},  // R7 hold detached
    {4'd7, 3'b110, 4'b0100},  // R7 reattach
    {4'd7, 3'b110, 4'b0100},  // R7 hold on phase low
    {4'd8, 3'b111, 4'b0111},  // R8 clear
    {4'd8, 3'b110, 4'b0100},  // R8 back to run
    {4'd4, 3'b010, 4'b1100},  // R4 stall
    {4'd4, 3'b010, 4'b1000},  // R4 detached-stalled
    {4'd4, 3'b011, 4'b1000},  // R4 hold
    {4'd4, 3'b110, 4'b1100},  // R4 back to attach-stalled
    {4'd2, 3'b111, 4'b0100},  // R2 run
    {4'd6, 3'b100, 4'b0100},  // R6 check state
    {4'd6, 3'b000, 4'b0000},  // R6 detach without ack
    {4'd7, 3'b111, 4'b0100},  // R7 reattach
    {4'd8, 3'b111, 4'b0111},  // R8 clear
    {4'd8, 3'b110, 4'b0100}   // R8 run
  };

  task automatic check_out(input int req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pause_o, connect_o, ack_o, clear_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: outputs {pause,connect,ack,clear} act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check_out(1, 4'b1000);  // R1 during reset
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {grant_i, home_req_i, cpu_phase_i} = VEC[i][6:4];
      @(posedge clk_i);
      #1 check_out(int'(VEC[i][10:7]), VEC[i][3:0]);
    end
    // R1: asynchronous reset from run
    @(negedge clk_i) rst_ni = 1'b0;
    #1 check_out(1, 4'b1000);
    @(negedge clk_i) rst_ni = 1'b1;
    {grant_i, home_req_i, cpu_phase_i} = 3'b110;
    @(posedge clk_i);
    #1 check_out(1, 4'b1100);
    // R9: run the stall path again, ack must stay low throughout
    @(negedge clk_i) cpu_phase_i = 1'b1;
    @(posedge clk_i); #1 check_out(2, 4'b0100);
    @(negedge clk_i) {grant_i, home_req_i, cpu_phase_i} = 3'b010;
    @(posedge clk_i); #1 check_out(9, 4'b1100);
    @(posedge clk_i); #1 check_out(9, 4'b1000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule